// File: doc/BRIEF.md
# Link Pulse Burst Generator

This block drives the idle-line integrity signalling of a 10 Mb/s twisted-pair transmitter. It runs from a free-running system clock and produces a single-bit pulse stream for the analog line driver. The mode select chooses between two forms of signalling. In normal mode the block emits one short, isolated pulse per period. In negotiation mode it emits a burst of pulses once per period. Each burst carries a 16-bit code word: a clock pulse opens every slot, and an optional data pulse sits partway through the slot.

All intervals are cycle counts. By default they are derived from the clock frequency in MHz: a 16 ms period, 125 µs between clock pulses, a data pulse 62 µs after its clock pulse, 114 ns burst pulses and 100 ns normal pulses. Every count can be overridden independently. The burst-active flag marks the cycles in which a burst is under way. Dropping the enable silences the output at once. Raising the enable again restarts the period, so a fresh pulse or burst follows straight away.

Top module: `link_pulse_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after any reset cycle, `pulse_o` and `burst_o` are low.
- R2: In normal mode (`mode_i` = 0) each pulse is high for exactly `NLP_W` cycles, and consecutive rising edges are exactly `PERIOD` cycles apart.
- R3: In normal mode `burst_o` never rises. A burst can begin only at a period start sampled with `mode_i` = 1.
- R4: In negotiation mode (`mode_i` = 1) `burst_o` rises once every `PERIOD` cycles and stays high for exactly 16·`GAP` + `FLP_W` + 1 cycles.
- R5: Each burst has 17 clock pulses. The first rises one cycle after `burst_o` rises, the rest follow every `GAP` cycles, and each is high for exactly `FLP_W` cycles. The last one falls in the same cycle as `burst_o`.
- R6: Bit i of the code word (bit 0 first, i = 0..15) produces a data pulse that rises exactly `DOFS` cycles after clock pulse i rises and is high for `FLP_W` cycles. A 0 bit produces no pulse in that slot.
- R7: The code word is captured at the start of each burst. A change to `word_i` while a burst is running shows up only in the next burst.
- R8: When `en_i` is low at a clock edge, both outputs are low from the next cycle and stay low while `en_i` stays low. In the first edge with `en_i` high again, a period begins: in normal mode `pulse_o` is high in the next cycle, and in negotiation mode `burst_o` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables pulse generation; low silences and restarts the block |
| mode_i | input | 1 | 0 = single normal pulses, 1 = code-word bursts |
| word_i | input | 16 | Code word, sent bit 0 first |
| pulse_o | output | 1 | Pulse stream toward the line driver |
| burst_o | output | 1 | High while a burst is in progress |

## Verification
The assertions assume that `mode_i` changes only while `en_i` is low or between bursts. They also assume the interval parameters are consistent: `FLP_W` < `DOFS`, `DOFS` + `FLP_W` < `GAP`, and a whole burst fits in one period. The stimulus keeps to these assumptions. It uses one compact, consistent set of counts, and it changes the mode only after a disabled phase, so every run starts from a cleared period counter. Code words change only in the middle of a burst, which exercises the capture rule without breaking the mode assumption.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    localparam int WORD_W = 16;
    localparam int SLOTS  = WORD_W + 1;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_BURST  = 1'b1
    } lpg_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_NORM  = 2'd1,
        SRC_CLOCK = 2'd2,
        SRC_DATA  = 2'd3
    } pulse_src_e;

    typedef struct packed {
        logic       go;
        pulse_src_e src;
    } fire_req_t;

    function automatic int ns_to_cycles(input int mhz, input int ns);
        return (mhz * ns + 999) / 1000;
    endfunction

    function automatic int us_to_cycles(input int mhz, input int us);
        return mhz * us;
    endfunction

endpackage

// File: rtl/lpg_period_timer.sv
module lpg_period_timer #(
    parameter int PERIOD = 1600000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic epoch_o
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(PERIOD - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign epoch_o = en_i && (cnt_q == '0);

endmodule

// File: rtl/lpg_burst_seq.sv
module lpg_burst_seq
    import lpg_pkg::*;
#(
    parameter int GAP   = 12500,
    parameter int DOFS  = 6200,
    parameter int FLP_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              clk_fire_o,
    output logic              data_fire_o,
    output logic              active_o
);
    localparam int GW = $clog2(GAP);
    localparam int SW = $clog2(SLOTS + 1);

    typedef struct packed {
        logic              act;
        logic [GW-1:0]     gcnt;
        logic [SW-1:0]     slot;
        logic [WORD_W-1:0] bits;
    } seq_state_t;

    seq_state_t st_q;

    logic last_slot;
    logic slot_end;
    logic done;

    assign last_slot = (st_q.slot == SW'(SLOTS - 1));
    assign slot_end  = (st_q.gcnt == GW'(GAP - 1));
    assign done      = last_slot && (st_q.gcnt == GW'(FLP_W));

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            st_q <= '0;
        end else if (start_i) begin
            st_q.act  <= 1'b1;
            st_q.gcnt <= '0;
            st_q.slot <= '0;
            st_q.bits <= word_i;
        end else if (st_q.act) begin
            if (done) begin
                st_q.act <= 1'b0;
            end
            if (slot_end) begin
                st_q.gcnt <= '0;
                st_q.slot <= st_q.slot + 1'b1;
                st_q.bits <= st_q.bits >> 1;
            end else begin
                st_q.gcnt <= st_q.gcnt + 1'b1;
            end
        end
    end

    assign clk_fire_o  = st_q.act && (st_q.gcnt == '0);
    assign data_fire_o = st_q.act && !last_slot && (st_q.gcnt == GW'(DOFS)) && st_q.bits[0];
    assign active_o    = st_q.act;

endmodule

// File: rtl/lpg_pulse_shaper.sv
module lpg_pulse_shaper
    import lpg_pkg::*;
#(
    parameter int NLP_W = 10,
    parameter int FLP_W = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  fire_req_t fire_i,
    output logic      pulse_o
);
    localparam int WMAX = (NLP_W > FLP_W) ? NLP_W : FLP_W;
    localparam int RW   = $clog2(WMAX + 1);

    logic [RW-1:0] rem_q;
    logic [RW-1:0] load_w;
    logic          pulse_q;

    always_comb begin
        if (fire_i.src == SRC_NORM) begin
            load_w = RW'(NLP_W - 1);
        end else begin
            load_w = RW'(FLP_W - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            rem_q   <= '0;
            pulse_q <= 1'b0;
        end else if (fire_i.go) begin
            rem_q   <= load_w;
            pulse_q <= 1'b1;
        end else if (rem_q != '0) begin
            rem_q   <= rem_q - 1'b1;
            pulse_q <= 1'b1;
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/link_pulse_gen.sv
module link_pulse_gen
    import lpg_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int NLP_W   = ns_to_cycles(CLK_MHZ, 100),
    parameter int FLP_W   = ns_to_cycles(CLK_MHZ, 114),
    parameter int GAP     = us_to_cycles(CLK_MHZ, 125),
    parameter int DOFS    = us_to_cycles(CLK_MHZ, 62),
    parameter int PERIOD  = us_to_cycles(CLK_MHZ, 16000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              mode_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              pulse_o,
    output logic              burst_o
);
    lpg_mode_e mode;
    logic      epoch;
    logic      clk_fire;
    logic      data_fire;
    logic      active;
    fire_req_t fire;

    assign mode = lpg_mode_e'(mode_i);

    lpg_period_timer #(
        .PERIOD (PERIOD)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .epoch_o (epoch)
    );

    lpg_burst_seq #(
        .GAP   (GAP),
        .DOFS  (DOFS),
        .FLP_W (FLP_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .start_i     (epoch && (mode == MODE_BURST)),
        .word_i      (word_i),
        .clk_fire_o  (clk_fire),
        .data_fire_o (data_fire),
        .active_o    (active)
    );

    always_comb begin
        fire = '{go: 1'b0, src: SRC_NONE};
        if (clk_fire) begin
            fire = '{go: 1'b1, src: SRC_CLOCK};
        end else if (data_fire) begin
            fire = '{go: 1'b1, src: SRC_DATA};
        end else if (epoch && (mode == MODE_NORMAL)) begin
            fire = '{go: 1'b1, src: SRC_NORM};
        end
    end

    lpg_pulse_shaper #(
        .NLP_W (NLP_W),
        .FLP_W (FLP_W)
    ) u_shaper (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .fire_i  (fire),
        .pulse_o (pulse_o)
    );

    assign burst_o = active;

endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
    parameter int NLP_W = 10,
    parameter int FLP_W = 12,
    parameter int GAP   = 12500
) (
    input logic clk,
    input logic rst,
    input logic en_i,
    input logic mode_i,
    input logic pulse_o,
    input logic burst_o
);
    localparam int WMAX = (NLP_W > FLP_W) ? NLP_W : FLP_W;
    localparam int BLEN = 16 * GAP + FLP_W + 1;

    logic [31:0] hi_run;
    logic [31:0] burst_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run    <= '0;
            burst_run <= '0;
        end else begin
            hi_run    <= pulse_o ? hi_run + 1 : '0;
            burst_run <= burst_o ? burst_run + 1 : '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!pulse_o && !burst_o)); // R1
    AST_PULSE_WIDTH_CAP: assert property (@(posedge clk) disable iff (rst) pulse_o |-> (hi_run < WMAX)); // R2
    AST_BURST_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst) $rose(burst_o) |-> $past(mode_i)); // R3
    AST_BURST_LEN_CAP: assert property (@(posedge clk) disable iff (rst) burst_o |-> (burst_run < BLEN)); // R4
    AST_OFF_PULSE_LOW: assert property (@(posedge clk) disable iff (rst) !en_i |=> !pulse_o); // R8
    AST_OFF_BURST_LOW: assert property (@(posedge clk) disable iff (rst) !en_i |=> !burst_o); // R8

endmodule

bind link_pulse_gen lpg_checker #(
    .NLP_W (NLP_W),
    .FLP_W (FLP_W),
    .GAP   (GAP)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .mode_i  (mode_i),
    .pulse_o (pulse_o),
    .burst_o (burst_o)
);

// File: tb/sim_link_pulse_gen.sv
`timescale 1ns/1ps
module sim_link_pulse_gen;
    localparam int NW  = 3;
    localparam int FW  = 4;
    localparam int GP  = 20;
    localparam int DO  = 10;
    localparam int PER = 500;
    localparam int BL  = 16 * GP + FW + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] word = '0;
    logic        pulse;
    logic        burst;

    int nchk = 0;
    int nerr = 0;

    int cyc = 0;
    int np = 0, nf = 0, nb = 0, nbf = 0;
    int rise_t [256];
    int wid    [256];
    int brise  [16];
    int blen   [16];
    logic p_q = 1'b0, b_q = 1'b0;

    always #5 clk = ~clk;

    link_pulse_gen #(
        .CLK_MHZ (100),
        .NLP_W   (NW),
        .FLP_W   (FW),
        .GAP     (GP),
        .DOFS    (DO),
        .PERIOD  (PER)
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en),
        .mode_i  (mode),
        .word_i  (word),
        .pulse_o (pulse),
        .burst_o (burst)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pulse && !p_q && np < 256) begin rise_t[np] = cyc; np = np + 1; end
        if (!pulse && p_q && nf < 256) begin wid[nf] = cyc - rise_t[nf]; nf = nf + 1; end
        if (burst && !b_q && nb < 16) begin brise[nb] = cyc; nb = nb + 1; end
        if (!burst && b_q && nbf < 16) begin blen[nbf] = cyc - brise[nbf]; nbf = nbf + 1; end
        p_q = pulse;
        b_q = burst;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        np = 0; nf = 0; nb = 0; nbf = 0;
    endtask

    task automatic disable_phase();
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_burst(input int b, input logic [15:0] w, inout int p);
        int base;
        base = brise[b];
        chk(blen[b] == BL, "R4 burst length", blen[b], BL);
        for (int i = 0; i < 17; i++) begin
            chk(rise_t[p] == base + 1 + i * GP, "R5 clock pulse rise", rise_t[p], base + 1 + i * GP);
            chk(wid[p] == FW, "R5 clock pulse width", wid[p], FW);
            p++;
            if (i < 16 && w[i]) begin
                chk(rise_t[p] == base + 1 + i * GP + DO, "R6 data pulse rise", rise_t[p], base + 1 + i * GP + DO);
                chk(wid[p] == FW, "R6 data pulse width", wid[p], FW);
                p++;
            end
        end
    endtask

    task automatic run_burst(input logic [15:0] w0, input logic [15:0] w1);
        int p;
        int exp_n;
        disable_phase();
        mode = 1'b1;
        word = w0;
        clear_log();
        en = 1'b1;
        @(negedge clk);
        chk(burst == 1'b1, "R8 burst restarts after enable", burst, 1);
        chk(pulse == 1'b0, "R5 no pulse with burst flag edge", pulse, 0);
        @(negedge clk);
        chk(pulse == 1'b1, "R5 first clock pulse", pulse, 1);
        repeat (40) @(negedge clk);
        word = w1;
        repeat (PER + 17 * GP) @(negedge clk);
        exp_n = 34 + $countones(w0) + $countones(w1);
        chk(nb == 2, "R4 burst count", nb, 2);
        chk(np == exp_n, "R7 pulse count", np, exp_n);
        chk(brise[1] - brise[0] == PER, "R4 burst spacing", brise[1] - brise[0], PER);
        p = 0;
        check_burst(0, w0, p);
        check_burst(1, w1, p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int quiet_bad;
        repeat (4) @(negedge clk);
        chk(pulse == 1'b0, "R1 pulse low in reset", pulse, 0);
        chk(burst == 1'b0, "R1 burst low in reset", burst, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pulse == 1'b0 && burst == 1'b0, "R1 quiet after reset", pulse, 0);

        // R2 and R3: normal mode
        disable_phase();
        mode = 1'b0;
        clear_log();
        en = 1'b1;
        @(negedge clk);
        chk(pulse == 1'b1, "R8 normal pulse after enable", pulse, 1);
        repeat (3 * PER + 10) @(negedge clk);
        chk(np == 4, "R2 normal pulse count", np, 4);
        for (int i = 0; i < 3; i++) begin
            chk(rise_t[i + 1] - rise_t[i] == PER, "R2 normal spacing", rise_t[i + 1] - rise_t[i], PER);
            chk(wid[i] == NW, "R2 normal width", wid[i], NW);
        end
        chk(nb == 0, "R3 no burst in normal mode", nb, 0);

        // R8: cut a normal pulse short
        disable_phase();
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(pulse == 1'b0, "R8 pulse cut on disable", pulse, 0);

        // R6 and R7: bursts with word changes
        run_burst(16'hA5C3, 16'h3C5A);
        run_burst(16'h0000, 16'hFFFF);
        run_burst(16'h0001, 16'h8000);

        // R8: disable during a burst data pulse
        disable_phase();
        mode = 1'b1;
        word = 16'hFFFF;
        en = 1'b1;
        repeat (2 + DO) @(negedge clk);
        chk(pulse == 1'b1 && burst == 1'b1, "R6 data pulse present", pulse, 1);
        en = 1'b0;
        quiet_bad = 0;
        repeat (2 * PER) begin
            @(negedge clk);
            if (pulse || burst) quiet_bad++;
        end
        chk(quiet_bad == 0, "R8 silent while disabled", quiet_bad, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule